// File: doc/BRIEF.md
# Four-Slot Transmit Descriptor Engine

This block runs the transmit side of a small Ethernet controller. The host has four fixed descriptor slots. Each slot has a buffer-address register and a status word. When the host writes a non-zero frame length into a slot's status word, that slot passes to the hardware. The engine services slots strictly in turn. It reads the frame one byte per request from memory into an internal byte buffer, then streams the bytes to the MAC over a valid/ready byte interface. The MAC appends the frame check sequence. Nothing pads short frames, so the host supplies at least 60 bytes.

A per-slot early-start threshold, given in 32-byte units, sets how much of the frame must be in the buffer before the first byte leaves. When a frame finishes, the slot returns to the host with a completion flag, and a write-one-to-clear interrupt status register records the result. If the MAC aborts a frame, the slot returns without the completion flag, the error bit is set, and the slot index stays where it is.

Top module: `txd_ring`

## Requirements
- R1: After reset every slot status word reads 0x0000_2000 (host-owned, no completion). The interrupt status register at 0x3C reads 0, and `tx_valid` and `mem_rd_en` are low.
- R2: The status word of slot n is at 0x10+4n and its address register is at 0x20+4n. Writing a status word with a non-zero length in bits 12:0 and a threshold in bits 21:16 hands the slot to the hardware. Bit 13 (host-owned) then reads 0, and the length and threshold read back as written.
- R3: A status write with length 0 is ignored. While a slot is owned by the hardware (bit 13 = 0), writes to its status word and to its address register are ignored.
- R4: The bytes of a frame come from memory addresses base to base+length-1, in increasing order. Each is emitted on `tx_data` and accepted when `tx_valid` and `tx_ready` are both high. `tx_last` marks only the final byte. While a byte is not accepted, `tx_valid` and `tx_data` hold.
- R5: The first byte of a frame is not emitted until one of three conditions holds: more than threshold×32 bytes have arrived from memory, the whole frame has arrived, or the internal buffer is full.
- R6: Slots are served strictly in index order, starting at slot 0. The index advances by one, modulo 4, only after a frame completes. A hardware-owned slot that is not the current one waits. Memory data is valid on `mem_rd_data` one cycle after `mem_rd_en`.
- R7: On completion the slot's status word reads with bit 13 = 1 and bit 15 (completed OK) = 1, and bit 2 of the interrupt status register is set.
- R8: A pulse on `tx_abort` during a frame has three effects. The slot returns to the host with bit 15 = 0, bit 3 of the interrupt status register is set, and no further bytes of that frame are emitted. The slot index does not advance.
- R9: Writing the interrupt status register clears exactly the bits written as 1. Bits written as 0 are unchanged.
- R10: The engine never issues more memory reads than the internal buffer can hold, so no fetched byte is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | REG_AW | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_rd_en | output | 1 | Memory byte read request |
| mem_rd_addr | output | AW | Memory byte address |
| mem_rd_data | input | 8 | Memory read data, one cycle after request |
| tx_valid | output | 1 | Byte available to the MAC |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | MAC accepts the byte |
| tx_abort | input | 1 | MAC aborts the current frame |

## Verification
The embedded properties check four things every cycle. The buffer never overflows or underflows. A stalled byte holds steady. The engine only works on, and only completes, a slot that the hardware owns. A busy slot's length never changes under a host write, and an interrupt bit only rises after a matching completion. Only the bench scenarios can show the byte contents and their address order, when the first byte is released under each start condition, and the serving order when a later slot is armed first. The same holds for the return of an aborted slot and for retrying it under an index that did not move.

// File: rtl/txd_pkg.sv
package txd_pkg;
   localparam int unsigned LEN_W     = 13;
   localparam int unsigned THR_W     = 6;
   localparam int unsigned ISR_W     = 16;
   localparam int unsigned STAT_BASE = 'h10;
   localparam int unsigned ADDR_BASE = 'h20;
   localparam int unsigned ISR_OFF   = 'h3C;
   localparam int unsigned OWN_BIT   = 13;
   localparam int unsigned OKF_BIT   = 15;
   localparam int unsigned THR_LSB   = 16;
   localparam int unsigned IRQ_OK    = 2;
   localparam int unsigned IRQ_ERR   = 3;

   typedef enum logic [0:0] {ST_IDLE, ST_RUN} eng_state_t;
endpackage

// File: rtl/txd_fifo.sv
module txd_fifo #(
   parameter  int unsigned DEPTH = 256,
   parameter  int unsigned W     = 8,
   localparam int unsigned PW    = $clog2(DEPTH),
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   input  logic          pop,
   output logic [W-1:0]  rdata,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("txd_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  store [DEPTH];
   logic [PW-1:0] wp, rp;

   assign full  = count == CW'(DEPTH);
   assign empty = count == '0;
   assign rdata = store[rp];

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         count <= count + CW'(push) - CW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push && !clr) store[wp] <= wdata;
   end

   AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) push && !clr |-> !full)
      else $error("push into full buffer");   // R10
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop && !clr |-> !empty)
      else $error("pop from empty buffer");   // R4
endmodule

// File: rtl/txd_regs.sv
module txd_regs import txd_pkg::*; #(
   parameter  int unsigned NSLOT  = 4,
   parameter  int unsigned AW     = 32,
   parameter  int unsigned REG_AW = 8,
   localparam int unsigned SW     = $clog2(NSLOT)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [REG_AW-1:0]           reg_addr,
   input  logic                        reg_wr,
   input  logic [31:0]                 reg_wdata,
   output logic [31:0]                 reg_rdata,
   output logic [NSLOT-1:0]            slot_busy,
   output logic [NSLOT-1:0][LEN_W-1:0] slot_len,
   output logic [NSLOT-1:0][THR_W-1:0] slot_thr,
   output logic [NSLOT-1:0][AW-1:0]    slot_addr,
   input  logic                        done_stb,
   input  logic                        done_ok,
   input  logic [SW-1:0]               done_slot
);
   logic [NSLOT-1:0][31:0] stat_word;
   logic [ISR_W-1:0]       isr, isr_set, isr_clr;
   logic                   isr_hit;
   logic                   unused_wdata;

   assign unused_wdata = ^reg_wdata[31:THR_LSB+THR_W];

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      localparam logic [REG_AW-1:0] SOFF = REG_AW'(STAT_BASE + 4*g);
      localparam logic [REG_AW-1:0] AOFF = REG_AW'(ADDR_BASE + 4*g);
      logic             busy_q, ok_q, stat_hit, addr_hit, mine_done;
      logic [LEN_W-1:0] len_q;
      logic [THR_W-1:0] thr_q;
      logic [AW-1:0]    addr_q;

      assign stat_hit  = reg_wr && reg_addr == SOFF;
      assign addr_hit  = reg_wr && reg_addr == AOFF;
      assign mine_done = done_stb && done_slot == SW'(g);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            busy_q <= 1'b0;
            ok_q   <= 1'b0;
            len_q  <= '0;
            thr_q  <= '0;
            addr_q <= '0;
         end else begin
            if (mine_done) begin
               busy_q <= 1'b0;
               ok_q   <= done_ok;
            end else if (stat_hit && !busy_q && reg_wdata[LEN_W-1:0] != '0) begin
               busy_q <= 1'b1;
               ok_q   <= 1'b0;
               len_q  <= reg_wdata[LEN_W-1:0];
               thr_q  <= reg_wdata[THR_LSB +: THR_W];
            end
            if (addr_hit && !busy_q) addr_q <= reg_wdata[AW-1:0];
         end
      end

      assign slot_busy[g] = busy_q;
      assign slot_len[g]  = len_q;
      assign slot_thr[g]  = thr_q;
      assign slot_addr[g] = addr_q;
      assign stat_word[g] = {10'd0, thr_q, ok_q, 1'b0, !busy_q, len_q};

      AST_BUSY_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
         busy_q && stat_hit |=> $stable(len_q))
         else $error("busy slot length overwritten");   // R3
   end

   assign isr_hit = reg_wr && reg_addr == REG_AW'(ISR_OFF);
   assign isr_clr = isr_hit ? reg_wdata[ISR_W-1:0] : '0;

   always_comb begin
      isr_set = '0;
      isr_set[IRQ_OK]  = done_stb && done_ok;
      isr_set[IRQ_ERR] = done_stb && !done_ok;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) isr <= '0;
      else        isr <= (isr & ~isr_clr) | isr_set;
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == REG_AW'(ISR_OFF)) reg_rdata = 32'(isr);
      for (int i = 0; i < NSLOT; i++) begin
         if (reg_addr == REG_AW'(STAT_BASE + 4*i)) reg_rdata = stat_word[i];
         if (reg_addr == REG_AW'(ADDR_BASE + 4*i)) reg_rdata = 32'(slot_addr[i]);
      end
   end

   AST_DONE_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_stb |-> slot_busy[done_slot])
      else $error("completion for a host-owned slot");   // R7
   AST_OK_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(isr[IRQ_OK]) |-> $past(done_stb && done_ok))
      else $error("ok interrupt without completion");   // R7
endmodule

// File: rtl/txd_engine.sv
module txd_engine import txd_pkg::*; #(
   parameter  int unsigned NSLOT      = 4,
   parameter  int unsigned AW         = 32,
   parameter  int unsigned FIFO_DEPTH = 256,
   localparam int unsigned SW         = $clog2(NSLOT),
   localparam int unsigned CW         = $clog2(FIFO_DEPTH + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NSLOT-1:0]            slot_busy,
   input  logic [NSLOT-1:0][LEN_W-1:0] slot_len,
   input  logic [NSLOT-1:0][THR_W-1:0] slot_thr,
   input  logic [NSLOT-1:0][AW-1:0]    slot_addr,
   output logic                        mem_rd_en,
   output logic [AW-1:0]               mem_rd_addr,
   input  logic [7:0]                  mem_rd_data,
   output logic                        tx_valid,
   output logic [7:0]                  tx_data,
   output logic                        tx_last,
   input  logic                        tx_ready,
   input  logic                        tx_abort,
   output logic                        done_stb,
   output logic                        done_ok,
   output logic [SW-1:0]               done_slot
);
   eng_state_t       state;
   logic [SW-1:0]    cur;
   logic [LEN_W-1:0] f_len, iss_cnt, fetched, sent_cnt, thr_bytes;
   logic [THR_W-1:0] f_thr;
   logic [AW-1:0]    f_addr;
   logic             rd_pend, started, run;
   logic             push, pop, clr, ffull, fempty;
   logic [CW-1:0]    fcnt;

   assign run       = state == ST_RUN;
   assign thr_bytes = LEN_W'({f_thr, 5'b0});

   assign mem_rd_en   = run && !tx_abort && iss_cnt < f_len &&
                        (fcnt + CW'(rd_pend)) < CW'(FIFO_DEPTH);
   assign mem_rd_addr = f_addr + AW'(iss_cnt);
   assign push        = run && rd_pend;

   assign tx_valid  = run && started && !fempty;
   assign tx_last   = sent_cnt == f_len - 1'b1;
   assign pop       = tx_valid && tx_ready;
   assign clr       = run && tx_abort;
   assign done_stb  = clr || (pop && tx_last);
   assign done_ok   = !tx_abort;
   assign done_slot = cur;

   txd_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .push  (push),
      .wdata (mem_rd_data),
      .pop   (pop),
      .rdata (tx_data),
      .count (fcnt),
      .full  (ffull),
      .empty (fempty)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cur      <= '0;
         f_len    <= '0;
         f_thr    <= '0;
         f_addr   <= '0;
         iss_cnt  <= '0;
         fetched  <= '0;
         sent_cnt <= '0;
         started  <= 1'b0;
         rd_pend  <= 1'b0;
      end else begin
         rd_pend <= mem_rd_en;
         case (state)
            ST_IDLE: begin
               if (slot_busy[cur]) begin
                  state    <= ST_RUN;
                  f_len    <= slot_len[cur];
                  f_thr    <= slot_thr[cur];
                  f_addr   <= slot_addr[cur];
                  iss_cnt  <= '0;
                  fetched  <= '0;
                  sent_cnt <= '0;
                  started  <= 1'b0;
               end
            end
            ST_RUN: begin
               if (mem_rd_en) iss_cnt  <= iss_cnt + 1'b1;
               if (push)      fetched  <= fetched + 1'b1;
               if (pop)       sent_cnt <= sent_cnt + 1'b1;
               if (fetched > thr_bytes || fetched == f_len || ffull) started <= 1'b1;
               if (clr) begin
                  state <= ST_IDLE;
               end else if (pop && tx_last) begin
                  state <= ST_IDLE;
                  cur   <= cur + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_SERVE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> slot_busy[cur])
      else $error("engine working on a host-owned slot");   // R6
   AST_STALL_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready && !tx_abort |=> tx_valid && $stable(tx_data))
      else $error("stalled byte changed");   // R4
endmodule

// File: rtl/txd_ring.sv
module txd_ring import txd_pkg::*; #(
   parameter  int unsigned NSLOT      = 4,
   parameter  int unsigned AW         = 32,
   parameter  int unsigned REG_AW     = 8,
   parameter  int unsigned FIFO_DEPTH = 256,
   localparam int unsigned SW         = $clog2(NSLOT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_rd_en,
   output logic [AW-1:0]     mem_rd_addr,
   input  logic [7:0]        mem_rd_data,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              tx_last,
   input  logic              tx_ready,
   input  logic              tx_abort
);
   if (NSLOT < 2 || NSLOT > 4 || (NSLOT & (NSLOT - 1)) != 0) begin : g_bad_slots
      $error("txd_ring: NSLOT must be 2 or 4");
   end
   if (AW > 32 || AW < LEN_W) begin : g_bad_aw
      $error("txd_ring: AW must lie between the length width and 32");
   end
   if (REG_AW < 6) begin : g_bad_regaw
      $error("txd_ring: REG_AW too small for the register map");
   end

   logic [NSLOT-1:0]            slot_busy;
   logic [NSLOT-1:0][LEN_W-1:0] slot_len;
   logic [NSLOT-1:0][THR_W-1:0] slot_thr;
   logic [NSLOT-1:0][AW-1:0]    slot_addr;
   logic                        done_stb, done_ok;
   logic [SW-1:0]               done_slot;

   txd_regs #(.NSLOT(NSLOT), .AW(AW), .REG_AW(REG_AW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .slot_busy (slot_busy),
      .slot_len  (slot_len),
      .slot_thr  (slot_thr),
      .slot_addr (slot_addr),
      .done_stb  (done_stb),
      .done_ok   (done_ok),
      .done_slot (done_slot)
   );

   txd_engine #(.NSLOT(NSLOT), .AW(AW), .FIFO_DEPTH(FIFO_DEPTH)) u_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .slot_busy   (slot_busy),
      .slot_len    (slot_len),
      .slot_thr    (slot_thr),
      .slot_addr   (slot_addr),
      .mem_rd_en   (mem_rd_en),
      .mem_rd_addr (mem_rd_addr),
      .mem_rd_data (mem_rd_data),
      .tx_valid    (tx_valid),
      .tx_data     (tx_data),
      .tx_last     (tx_last),
      .tx_ready    (tx_ready),
      .tx_abort    (tx_abort),
      .done_stb    (done_stb),
      .done_ok     (done_ok),
      .done_slot   (done_slot)
   );
endmodule

// File: tb/txd_ring_bench.sv
module txd_ring_bench;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] ISR_A = 8'h3C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_rd_en;
   logic [31:0] mem_rd_addr;
   logic [7:0]  mem_rd_data = '0;
   logic        tx_valid, tx_last;
   logic [7:0]  tx_data;
   logic        tx_ready = 1'b0;
   logic        tx_abort = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   txd_ring u_txd_ring (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd_en(mem_rd_en),
      .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .tx_valid(tx_valid),
      .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready), .tx_abort(tx_abort)
   );

   function automatic logic [7:0] mbyte(input logic [31:0] a);
      return a[7:0] ^ a[15:8] ^ 8'hA5;
   endfunction

   always @(posedge clk) if (mem_rd_en) mem_rd_data <= mbyte(mem_rd_addr);

   logic [7:0] lfsr = 8'h01;
   bit stall_mode = 0, hold_low = 0;
   always @(posedge clk) begin
      lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tx_ready <= !hold_low && (!stall_mode || lfsr[0]);
   end

   logic [7:0] cap_data [1024];
   bit         cap_last [1024];
   int cap_n = 0, rd_cnt = 0, rd_at_start = 0;
   bit seen_valid = 0;
   int n_chk = 0, n_fail = 0, cyc = 0;

   always @(negedge clk) begin
      if (tx_valid && !seen_valid) begin seen_valid = 1; rd_at_start = rd_cnt; end
      if (mem_rd_en) rd_cnt++;
      if (tx_valid && tx_ready && !tx_abort && cap_n < 1024) begin
         cap_data[cap_n] = tx_data;
         cap_last[cap_n] = tx_last;
         cap_n++;
      end
   end

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] soff(input int s); return 8'(8'h10 + 4*s); endfunction
   function automatic logic [7:0] aoff(input int s); return 8'(8'h20 + 4*s); endfunction

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(posedge clk); #2; reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk); #2; reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(posedge clk); #2; reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic clear_cap();
      @(posedge clk); #2;
      cap_n = 0; rd_cnt = 0; rd_at_start = 0; seen_valid = 0;
   endtask

   task automatic wait_free(input int s);
      logic [31:0] v;
      int k = 0;
      do begin rd(soff(s), v); k++; end while (!v[13] && k < 20000);
   endtask

   task automatic start(input int s, input int addr, input int len, input int thr);
      wr(aoff(s), 32'(addr));
      wr(soff(s), (32'(thr) << 16) | 32'(len));
   endtask

   task automatic chk_bytes(input int base, input int addr, input int len, input string req);
      int bad = 0, lbad = 0;
      for (int k = 0; k < len; k++) begin
         if (cap_data[base+k] !== mbyte(32'(addr + k))) bad++;
         if (cap_last[base+k] !== (k == len - 1)) lbad++;
      end
      chk(bad == 0, {req, " data"}, 32'(bad), 0);
      chk(lbad == 0, {req, " last marker"}, 32'(lbad), 0);
   endtask

   localparam int NV = 5;
   localparam int          V_ADDR  [NV] = '{'h040, 'h1F3, 'h300, 'h3FD, 'h080};
   localparam int          V_LEN   [NV] = '{60, 64, 61, 100, 75};
   localparam int          V_THR   [NV] = '{0, 1, 3, 63, 2};
   localparam bit          V_STALL [NV] = '{0, 1, 0, 1, 1};
   localparam logic [15:0] V_ISR   [NV] = '{16'h0004, 16'h0004, 16'h0004, 16'h0004, 16'h0004};

   initial begin
      logic [31:0] v;
      int s, n;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1: reset state
      for (int i = 0; i < 4; i++) begin
         rd(soff(i), v);
         chk(v === 32'h0000_2000, "R1 slot status after reset", v, 32'h2000);
      end
      rd(ISR_A, v);
      chk(v === 0, "R1 interrupt status after reset", v, 0);
      chk(!tx_valid && !mem_rd_en, "R1 idle outputs", {tx_valid, mem_rd_en}, 0);

      // R4 R6 R7: table of frames over slots 0..3 then wrap to 0
      for (int i = 0; i < NV; i++) begin
         s = i % 4;
         clear_cap();
         stall_mode = V_STALL[i];
         start(s, V_ADDR[i], V_LEN[i], V_THR[i]);
         wait_free(s);
         repeat (2) @(posedge clk);
         chk(cap_n == V_LEN[i], "R4 byte count", 32'(cap_n), 32'(V_LEN[i]));
         chk_bytes(0, V_ADDR[i], V_LEN[i], "R4 R6");
         rd(soff(s), v);
         chk(v === {10'd0, 6'(V_THR[i]), 1'b1, 1'b0, 1'b1, 13'(V_LEN[i])},
             "R7 status after completion", v, {10'd0, 6'(V_THR[i]), 3'b101, 13'(V_LEN[i])});
         rd(ISR_A, v);
         chk(v[15:0] === V_ISR[i], "R7 interrupt status", v, 32'(V_ISR[i]));
         wr(ISR_A, 32'h000C);
      end
      stall_mode = 0;

      // R2 R3: slot 1 held busy by a stalled MAC
      clear_cap();
      hold_low = 1;
      start(1, 'h500, 64, 2);
      rd(soff(1), v);
      chk(v[13] == 1'b0 && v[12:0] == 13'd64 && v[21:16] == 6'd2, "R2 armed status", v, 32'h0002_0040);
      wr(soff(1), 32'd80);
      wr(aoff(1), 32'h900);
      rd(soff(1), v);
      chk(v[12:0] == 13'd64, "R3 busy status write ignored", 32'(v[12:0]), 64);
      rd(aoff(1), v);
      chk(v == 32'h500, "R3 busy address write ignored", v, 32'h500);
      wr(soff(2), 32'h0003_0000);
      rd(soff(2), v);
      chk(v[13] == 1'b1, "R3 zero length write ignored", v, 32'h2000);
      hold_low = 0;
      wait_free(1);
      repeat (2) @(posedge clk);
      chk(cap_n == 64, "R3 byte count", 32'(cap_n), 64);
      chk_bytes(0, 'h500, 64, "R3");
      wr(ISR_A, 32'h000C);

      // R6: slot 3 armed before the current slot 2 must wait
      clear_cap();
      start(3, 'h700, 60, 0);
      repeat (50) @(posedge clk);
      chk(cap_n == 0 && rd_cnt == 0, "R6 later slot waits", 32'(cap_n + rd_cnt), 0);
      start(2, 'h600, 61, 0);
      wait_free(3);
      repeat (2) @(posedge clk);
      chk(cap_n == 121, "R6 two frame byte count", 32'(cap_n), 121);
      chk_bytes(0, 'h600, 61, "R6 first");
      chk_bytes(61, 'h700, 60, "R6 second");
      wr(ISR_A, 32'h000C);

      // R5: start conditions, slots 0, 1, 2
      clear_cap();
      start(0, 'h220, 100, 1);
      wait_free(0);
      chk(rd_at_start >= 33 && rd_at_start < 100, "R5 threshold start", 32'(rd_at_start), 33);
      clear_cap();
      start(1, 'h2A0, 60, 5);
      wait_free(1);
      chk(rd_at_start == 60, "R5 whole frame start", 32'(rd_at_start), 60);
      clear_cap();
      start(2, 'h400, 300, 63);
      wait_free(2);
      repeat (2) @(posedge clk);
      chk(rd_at_start == 256, "R5 R10 buffer full start", 32'(rd_at_start), 256);
      chk_bytes(0, 'h400, 300, "R10");
      wr(ISR_A, 32'h000C);

      // R8: abort on slot 3
      clear_cap();
      start(3, 'h100, 200, 0);
      n = 0;
      while (cap_n < 10 && n < 5000) begin @(posedge clk); n++; end
      @(posedge clk); #2 tx_abort = 1'b1;
      @(posedge clk); #2 tx_abort = 1'b0;
      n = cap_n;
      repeat (20) @(posedge clk);
      chk(cap_n == n && !tx_valid, "R8 output stops after abort", 32'(cap_n), 32'(n));
      rd(soff(3), v);
      chk(v[13] == 1'b1 && v[15] == 1'b0, "R8 slot returned without ok", v, 32'h2000);
      rd(ISR_A, v);
      chk(v === 32'h0008, "R8 error interrupt", v, 32'h0008);

      // R9: writing zero leaves bits alone
      wr(ISR_A, 32'h0000);
      rd(ISR_A, v);
      chk(v === 32'h0008, "R9 zero write keeps bits", v, 32'h0008);

      // R8: index did not advance, slot 3 is served again
      clear_cap();
      start(3, 'h140, 60, 0);
      wait_free(3);
      repeat (2) @(posedge clk);
      chk(cap_n == 60, "R8 retry on same slot", 32'(cap_n), 60);
      chk_bytes(0, 'h140, 60, "R8 retry");
      rd(ISR_A, v);
      chk(v === 32'h000C, "R9 both bits set", v, 32'h000C);
      wr(ISR_A, 32'h0004);
      rd(ISR_A, v);
      chk(v === 32'h0008, "R9 clear only ok bit", v, 32'h0008);
      wr(ISR_A, 32'h0008);
      rd(ISR_A, v);
      chk(v === 32'h0000, "R9 clear error bit", v, 0);

      summary();
      $finish;
   end
endmodule